// File: doc/BRIEF.md
# Timing-Reference Clipper and Sync Detector

This block sits after the descrambler and de-dither logic of a serial video receiver. It takes parallel video words that are already aligned, one or more 10-bit lanes per word, and applies LSB clipping to each lane on its own. A lane value at the very bottom of the code range is set to exactly zero. A lane value at the very top is set to exactly all-ones. A sync search runs on the clipped stream, so a preamble that arrives with small errors in its low bits is still found.

The detector watches lane 0 for a preamble of three words. It decodes the word that comes after the preamble and reports whether that word marks the end or the start of active video. It also outputs the field and vertical-blanking bits from that word. A counter of valid words, which wraps at the line length, gives the position of each sync word. When a sync word lands somewhere other than the stored position, a new-position pulse is raised. A framing-enable input decides whether the new position replaces the stored one. All outputs come from registers and appear two clock edges after the input word.

Top module: `trs_clip_detect`

## Requirements
- R1: On every lane, an input value from 0x000 to 0x003 is output as 0x000.
- R2: On every lane, an input value from 0x3FC to 0x3FF is output as 0x3FF.
- R3: On every lane, any other input value is output unchanged. Lane k occupies word bits [10k+9:10k], and each lane is clipped independently of the others.
- R4: A word presented with in_valid high at clock edge n appears on out_word at edge n+2, with out_valid high. When in_valid is low at edge n, out_valid and every flag are low after edge n+2.
- R5: trs_flag is high on the output word when the three previous valid words of clipped lane 0 were 0x3FF, 0x000, 0x000, oldest first. Cycles with in_valid low between these words do not break the sequence.
- R6: On a word flagged by trs_flag, eav_flag equals bit 6 of lane 0 and sav_flag is its inverse. f_bit equals bit 8 and v_bit equals bit 7. All four are low on words that are not flagged.
- R7: Valid words are counted modulo LINE_LEN, starting from 0 at reset. nsp_flag pulses with a flagged word in two cases: no sync position has been stored yet, or the count of that word differs from the stored position.
- R8: frame_en is sampled together with the word. When nsp_flag fires and frame_en is high, the stored position becomes the word's count. When frame_en is low, the stored position is held, so a later preamble at the same new count raises nsp_flag again.
- R9: During and directly after reset, out_valid, out_word and all flags are zero, and no sync position is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word strobe |
| in_word | input | 10*NUM_CH | Descrambled word; lane 0 in bits [9:0] |
| frame_en | input | 1 | Accept a new sync position |
| out_valid | output | 1 | Output word strobe |
| out_word | output | 10*NUM_CH | Clipped word |
| trs_flag | output | 1 | Word follows a sync preamble |
| eav_flag | output | 1 | Sync word marks end of active video |
| sav_flag | output | 1 | Sync word marks start of active video |
| f_bit | output | 1 | Field bit of the sync word |
| v_bit | output | 1 | Vertical-blanking bit of the sync word |
| nsp_flag | output | 1 | Sync found at a new position |

## Verification
Four properties are checked on every clock cycle:
- no output lane ever holds a value inside the two clip bands;
- a flagged word carries exactly one of EAV and SAV;
- nothing is flagged on an invalid word;
- the stored position does not change while framing is disabled.

Other behaviour can only be shown by the bench scenarios:
- the exact value mapping over all 1024 codes;
- the two-edge timing;
- preamble recognition across idle cycles and from inputs that are only near full scale;
- the sequence of new-position pulses as the sync position moves with framing enabled and disabled.

// File: rtl/trs_pkg.sv
// Shared constants and types for the clip-and-detect block.
// Assumes 10-bit video lanes; clip band limits are fixed by the video format.
package trs_pkg;
    localparam int LANE_W      = 10;
    localparam logic [LANE_W-1:0] CODE_MIN    = 10'h000;
    localparam logic [LANE_W-1:0] CODE_MAX    = 10'h3FF;
    localparam logic [LANE_W-1:0] LOW_BAND_HI = 10'h003;
    localparam logic [LANE_W-1:0] HIGH_BAND_LO = 10'h3FC;
    localparam int BIT_F = 8;
    localparam int BIT_V = 7;
    localparam int BIT_H = 6;

    typedef struct packed {
        logic found;
        logic f;
        logic v;
        logic h;
    } sync_hit_t;
endpackage

// File: rtl/trs_lane_clip.sv
// Clips one 10-bit lane: the bottom band goes to zero, the top band to all-ones.
// Purely combinational; assumes the input is already descrambled and de-dithered.
module trs_lane_clip
    import trs_pkg::*;
(
    input  logic [LANE_W-1:0] lane_in,
    output logic [LANE_W-1:0] lane_out
);
    // map the two edge bands onto the exact code limits
    always_comb begin
        if (lane_in <= LOW_BAND_HI)       lane_out = CODE_MIN;
        else if (lane_in >= HIGH_BAND_LO) lane_out = CODE_MAX;
        else                              lane_out = lane_in;
    end
endmodule

// File: rtl/trs_preamble_det.sv
// Keeps the last three valid lane-0 words and decodes the word after a preamble.
// Assumes words arrive already clipped; idle cycles leave the history untouched.
module trs_preamble_det
    import trs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [LANE_W-1:0] word,
    output sync_hit_t         hit
);
    logic [LANE_W-1:0] hist_new, hist_mid, hist_old;

    // shift the history on every valid word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_new <= CODE_MIN;
            hist_mid <= CODE_MIN;
            hist_old <= CODE_MIN;
        end else if (valid) begin
            hist_old <= hist_mid;
            hist_mid <= hist_new;
            hist_new <= word;
        end
    end

    // recognise the preamble and extract the sync-word bits
    always_comb begin
        hit.found = valid && (hist_old == CODE_MAX) && (hist_mid == CODE_MIN)
                    && (hist_new == CODE_MIN);
        hit.f = hit.found && word[BIT_F];
        hit.v = hit.found && word[BIT_V];
        hit.h = hit.found && word[BIT_H];
    end
endmodule

// File: rtl/trs_sync_track.sv
// Counts valid words modulo LINE_LEN and compares each sync word's count with
// the stored sync position. A new position is stored only when frame_en is high.
module trs_sync_track
    import trs_pkg::*;
#(
    parameter int LINE_LEN = 2200
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      valid,
    input  sync_hit_t hit,
    input  logic      frame_en,
    output logic      nsp
);
    localparam int POS_W = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1;
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(LINE_LEN - 1);

    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] ofs;
    logic             have_ofs;

    // new position when nothing is stored yet or the count differs
    always_comb nsp = hit.found && (!have_ofs || (pos != ofs));

    // word counter, wraps at the line length
    always_ff @(posedge clk) begin
        if (!rst_n)          pos <= '0;
        else if (valid)      pos <= (pos == POS_LAST) ? '0 : pos + 1'b1;
    end

    // store the sync position only when framing is enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs      <= '0;
            have_ofs <= 1'b0;
        end else if (nsp && frame_en) begin
            ofs      <= pos;
            have_ofs <= 1'b1;
        end
    end

    assert_hold_offset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit.found && !frame_en) |=> ($stable(ofs) && $stable(have_ofs)));

    assert_pos_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= POS_LAST);
endmodule

// File: rtl/trs_clip_detect.sv
// Top level: clips every lane, registers the word (stage 1), runs the preamble
// detector and the position tracker on stage 1, and registers the results
// (stage 2). Assumes words are already aligned to word boundaries.
module trs_clip_detect
    import trs_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int LINE_LEN = 2200
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [NUM_CH*LANE_W-1:0] in_word,
    input  logic                     frame_en,
    output logic                     out_valid,
    output logic [NUM_CH*LANE_W-1:0] out_word,
    output logic                     trs_flag,
    output logic                     eav_flag,
    output logic                     sav_flag,
    output logic                     f_bit,
    output logic                     v_bit,
    output logic                     nsp_flag
);
    localparam int WORD_W = NUM_CH * LANE_W;

    logic [WORD_W-1:0] clipped;
    logic [WORD_W-1:0] s1_word;
    logic              s1_valid;
    logic              s1_fe;
    sync_hit_t         hit;
    logic              nsp;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        trs_lane_clip u_clip (
            .lane_in  (in_word[g*LANE_W +: LANE_W]),
            .lane_out (clipped[g*LANE_W +: LANE_W])
        );
    end

    // stage 1: hold the clipped word together with its strobe and framing enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_word  <= '0;
            s1_fe    <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            s1_fe    <= frame_en;
            if (in_valid) s1_word <= clipped;
        end
    end

    trs_preamble_det u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (s1_valid),
        .word  (s1_word[LANE_W-1:0]),
        .hit   (hit)
    );

    trs_sync_track #(.LINE_LEN(LINE_LEN)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (s1_valid),
        .hit      (hit),
        .frame_en (s1_fe),
        .nsp      (nsp)
    );

    // stage 2: register the output word and the sync flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
            trs_flag  <= 1'b0;
            eav_flag  <= 1'b0;
            sav_flag  <= 1'b0;
            f_bit     <= 1'b0;
            v_bit     <= 1'b0;
            nsp_flag  <= 1'b0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) out_word <= s1_word;
            trs_flag  <= hit.found;
            eav_flag  <= hit.found && hit.h;
            sav_flag  <= hit.found && !hit.h;
            f_bit     <= hit.f;
            v_bit     <= hit.v;
            nsp_flag  <= nsp;
        end
    end

    // true when no lane sits inside either clip band
    function automatic logic lanes_clean(input logic [WORD_W-1:0] w);
        logic ok;
        ok = 1'b1;
        for (int k = 0; k < NUM_CH; k++) begin
            if ((w[k*LANE_W +: LANE_W] > CODE_MIN && w[k*LANE_W +: LANE_W] <= LOW_BAND_HI) ||
                (w[k*LANE_W +: LANE_W] >= HIGH_BAND_LO && w[k*LANE_W +: LANE_W] < CODE_MAX))
                ok = 1'b0;
        end
        return ok;
    endfunction

    assert_clip_bands_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> lanes_clean(out_word));

    assert_one_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trs_flag |-> (eav_flag ^ sav_flag));

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(trs_flag || eav_flag || sav_flag || nsp_flag));

    assert_nsp_on_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
        nsp_flag |-> trs_flag);
endmodule

// File: tb/tb_trs_clip_detect.sv
// Bench: sweeps all lane codes, then streams short lines with moving sync
// positions, idle gaps and near-miss preambles against an arithmetic model.
module tb_trs_clip_detect;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 2;
    localparam int LLEN = 12;
    localparam int WW   = NCH * 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [WW-1:0] in_word = '0;
    logic          frame_en = 1'b0;
    logic          out_valid, trs_flag, eav_flag, sav_flag, f_bit, v_bit, nsp_flag;
    logic [WW-1:0] out_word;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        bit          vld;
        logic [WW-1:0] w;
        bit trs, eav, sav, f, v, nsp;
    } exp_t;

    exp_t d1, d2;
    logic [9:0] mh0, mh1, mh2;
    int  m_pos, m_ofs;
    bit  m_have;

    trs_clip_detect #(.NUM_CH(NCH), .LINE_LEN(LLEN)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .frame_en(frame_en), .out_valid(out_valid), .out_word(out_word),
        .trs_flag(trs_flag), .eav_flag(eav_flag), .sav_flag(sav_flag),
        .f_bit(f_bit), .v_bit(v_bit), .nsp_flag(nsp_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [9:0] clip(input logic [9:0] x);
        if (x <= 10'd3) return 10'd0;
        if (x >= 10'd1020) return 10'h3FF;
        return x;
    endfunction

    task automatic cmp(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // one word period: check the word sent two periods ago, then drive a new one
    task automatic step(input bit v, input logic [WW-1:0] w, input bit fe);
        exp_t n;
        logic [9:0] c0;
        bit hit;
        @(negedge clk);
        checks++;
        cmp("R4 out_valid", WW'(out_valid), WW'(d2.vld));
        if (d2.vld) cmp("R1 R2 R3 clipped word", out_word, d2.w);
        cmp("R5 trs_flag", WW'(trs_flag), WW'(d2.trs));
        cmp("R6 eav_flag", WW'(eav_flag), WW'(d2.eav));
        cmp("R6 sav_flag", WW'(sav_flag), WW'(d2.sav));
        cmp("R6 f_bit", WW'(f_bit), WW'(d2.f));
        cmp("R6 v_bit", WW'(v_bit), WW'(d2.v));
        cmp("R7 R8 nsp_flag", WW'(nsp_flag), WW'(d2.nsp));
        d2 = d1;
        n = '{vld:0, w:'0, trs:0, eav:0, sav:0, f:0, v:0, nsp:0};
        if (v) begin
            n.vld = 1;
            for (int k = 0; k < NCH; k++) n.w[k*10 +: 10] = clip(w[k*10 +: 10]);
            c0 = n.w[9:0];
            hit = (mh2 == 10'h3FF) && (mh1 == 10'h000) && (mh0 == 10'h000);
            if (hit) begin
                n.trs = 1;
                n.eav = c0[6];
                n.sav = !c0[6];
                n.f = c0[8];
                n.v = c0[7];
                n.nsp = !m_have || (m_pos != m_ofs);
                if (n.nsp && fe) begin
                    m_ofs = m_pos;
                    m_have = 1;
                end
            end
            mh2 = mh1; mh1 = mh0; mh0 = c0;
            m_pos = (m_pos + 1) % LLEN;
        end
        d1 = n;
        in_valid = v;
        in_word = w;
        frame_en = fe;
    endtask

    // watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        d1 = '{vld:0, w:'0, trs:0, eav:0, sav:0, f:0, v:0, nsp:0};
        d2 = d1;
        mh0 = 0; mh1 = 0; mh2 = 0;
        m_pos = 0; m_ofs = 0; m_have = 0;
        repeat (3) @(negedge clk);
        // R9: everything zero while reset is held
        checks++;
        cmp("R9 reset outputs", {out_word, out_valid, trs_flag, eav_flag, sav_flag, f_bit, v_bit, nsp_flag} , '0);
        rst_n = 1'b1;

        // R1 R2 R3: every code on lane 0, mirrored code on lane 1
        for (int c = 0; c < 1024; c++) step(1, {10'(1023 - c), 10'(c)}, 0);
        step(0, '0, 0);

        // R5-R8: lines with sync at varying places, framing on/off, idle gaps
        for (int ln = 0; ln < 22; ln++) begin
            int p;
            bit fe;
            p  = (ln < 6) ? 2 : (ln < 14) ? 5 : 7;
            fe = !(ln >= 6 && ln < 10);
            for (int i = 0; i < LLEN; i++) begin
                logic [9:0] lw;
                lw = 10'(10'h100 + i * 7);
                if (i == p)          lw = 10'(10'h3FC + ln % 4);
                else if (i == p + 1) lw = 10'(ln % 4);
                else if (i == p + 2) lw = (ln >= 20) ? 10'h004 : 10'(3 - ln % 4);
                else if (i == p + 3) lw = {1'b1, 1'(ln >> 2), 1'(ln >> 1), 1'(ln), 6'(ln)};
                step(1, {10'(10'h200 + i), lw}, fe);
                if (ln >= 14 && ln < 20 && ln[0]) step(0, '1, fe);
            end
        end
        repeat (3) step(0, '0, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule